// File: doc/BRIEF.md
# Cache Line Burst Engine for a 32-bit Wishbone Bus

The engine sits between a cache controller and a 32-bit Wishbone B3 master port and moves whole 128-bit cache lines. The cache controller raises one of two requests. An eviction request carries the address and the 128 bits of a dirty victim line. A refill request carries the address of a line to fetch. Each accepted request becomes a linear incrementing burst of four 32-bit beats. The last beat is marked as end of burst. For a refill, the four returned words are assembled into one 128-bit line.

The caches write back dirty data, so a victim must reach the bus before its replacement is fetched. When both requests are pending, the engine serves the eviction first. A requester holds its request and its operands until the matching one-cycle done pulse, and drops the request while that pulse is high. The engine captures the operands when it accepts a request, and it does not look at them again until the next acceptance.

The control is a five-state machine:

- **IDLE**: no bus cycle is open.
  - IDLE to PUSH when an eviction request is present.
  - IDLE to PULL when only a refill request is present.
- **PUSH**: write burst.
  - PUSH to PUSH_END on the acknowledge of the last beat.
- **PULL**: read burst.
  - PULL to PULL_END on the acknowledge of the last beat.
- **PUSH_END**: one cycle that pulses the eviction done output. It always returns to IDLE.
- **PULL_END**: one cycle that pulses the refill done output. It always returns to IDLE.

Top module: `wbl_burst_engine`

## Requirements
- R1: After a synchronous reset, the following outputs are 0: cyc, stb, both done pulses and the assembled refill line.
- R2: In the cycle after IDLE sees a request, cyc and stb are 1. The first beat address is the request address with its low 4 bits cleared.
- R3: The bus address advances by 4 after each acknowledged beat. While a beat waits for ack, the address holds.
- R4: cti is 3'b010 on beats 0 to 2 and 3'b111 on beat 3. bte is 2'b00 and sel is 4'b1111 whenever cyc is high.
- R5: During an eviction burst, we is 1 and beat k carries bits [32k+31:32k] of the victim line.
- R6: During a refill burst, we is 0, and the word acknowledged on beat k becomes bits [32k+31:32k] of the refill line. The refill line is complete when the refill done pulse is high.
- R7: cyc and stb drop in the cycle after the fourth ack. The done pulse of that request is high for exactly that one cycle, and the engine is back in IDLE in the cycle after it.
- R8: When an eviction request and a refill request are both present in IDLE, the eviction burst runs first, and the refill burst follows after its done pulse.
- R9: Outside a refill burst, the refill line output holds its last value.
- R10: Address and line inputs are captured at acceptance. Changing them during a burst has no effect on the addresses or data of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evict_req | input | 1 | Eviction request, held until evict_done |
| evict_addr | input | 32 | Victim line address |
| evict_line | input | 128 | Victim line data, word 0 in bits 31:0 |
| evict_done | output | 1 | One-cycle pulse after the eviction burst |
| refill_req | input | 1 | Refill request, held until refill_done |
| refill_addr | input | 32 | Address of the line to fetch |
| refill_line | output | 128 | Assembled refill line, word 0 in bits 31:0 |
| refill_done | output | 1 | One-cycle pulse after the refill burst |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | 32 | Byte address |
| wb_dat_o | output | 32 | Write data |
| wb_sel_o | output | 4 | Byte selects |
| wb_cti_o | output | 3 | Cycle type |
| wb_bte_o | output | 2 | Burst type |
| wb_ack_i | input | 1 | Beat acknowledge |
| wb_dat_i | input | 32 | Read data |

## Verification
Line moves are tried with three acknowledge patterns: ack on every cycle, ack on every other cycle, and a pseudo-random ack. These separate a correct address and data hold during waits from a design that advances on strobe alone. The request patterns are:
- an eviction alone, with an unaligned address;
- a refill alone;
- both requests raised together, which exposes the ordering;
- a refill with an eviction arriving mid-burst, which must not preempt it;
- an eviction whose inputs are scrambled mid-burst, which shows the capture at acceptance.

A behavioural model predicts every bus signal and the done pulses on every clock.

// File: rtl/wbl_pkg.sv
package wbl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH,
        ST_PULL,
        ST_PUSH_END,
        ST_PULL_END
    } wbl_state_e;

    localparam logic [2:0] CTI_INCR   = 3'b010;
    localparam logic [2:0] CTI_EOB    = 3'b111;
    localparam logic [1:0] BTE_LINEAR = 2'b00;

endpackage

// File: rtl/wbl_ctrl.sv
module wbl_ctrl
    import wbl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evict_req,
    input  logic refill_req,
    input  logic ack,
    input  logic last_beat,
    output logic start_push,
    output logic start_pull,
    output logic in_burst,
    output logic is_write,
    output logic evict_done,
    output logic refill_done
);

    wbl_state_e state_q;
    wbl_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (evict_req) begin
                    state_d = ST_PUSH;
                end else if (refill_req) begin
                    state_d = ST_PULL;
                end
            end
            ST_PUSH: begin
                if (ack && last_beat) begin
                    state_d = ST_PUSH_END;
                end
            end
            ST_PULL: begin
                if (ack && last_beat) begin
                    state_d = ST_PULL_END;
                end
            end
            ST_PUSH_END: state_d = ST_IDLE;
            ST_PULL_END: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start_push  = 1'b0;
        start_pull  = 1'b0;
        in_burst    = 1'b0;
        is_write    = 1'b0;
        evict_done  = 1'b0;
        refill_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start_push = evict_req;
                start_pull = !evict_req && refill_req;
            end
            ST_PUSH: begin
                in_burst = 1'b1;
                is_write = 1'b1;
            end
            ST_PULL: begin
                in_burst = 1'b1;
            end
            ST_PUSH_END: evict_done  = 1'b1;
            ST_PULL_END: refill_done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/wbl_beat_gen.sv
module wbl_beat_gen #(
    parameter int ADDR_W     = 32,
    parameter int BEATS      = 4,
    parameter int BEAT_BYTES = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         start_addr,
    input  logic                      step,
    output logic [$clog2(BEATS)-1:0]  beat_idx,
    output logic                      last_beat,
    output logic [ADDR_W-1:0]         bus_addr
);

    localparam int IDX_W      = $clog2(BEATS);
    localparam int LINE_BYTES = BEATS * BEAT_BYTES;
    localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LINE_BYTES - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX   = IDX_W'(BEATS - 1);

    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (start) begin
            base_q <= start_addr & ALIGN_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            cnt_q <= '0;
        end else if (step) begin
            if (cnt_q == LAST_IDX) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign beat_idx  = cnt_q;
    assign last_beat = (cnt_q == LAST_IDX);
    assign bus_addr  = base_q + (ADDR_W'(cnt_q) << BEAT_SHIFT);

endmodule

// File: rtl/wbl_line_buf.sv
module wbl_line_buf #(
    parameter int DATA_W = 32,
    parameter int BEATS  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      load_wr,
    input  logic [DATA_W*BEATS-1:0]   wr_line_in,
    input  logic                      capture,
    input  logic [$clog2(BEATS)-1:0]  beat_idx,
    input  logic [DATA_W-1:0]         rd_word_in,
    output logic [DATA_W-1:0]         wr_word_out,
    output logic [DATA_W*BEATS-1:0]   rd_line_out
);

    localparam int LINE_W = DATA_W * BEATS;

    logic [LINE_W-1:0] wr_q;
    logic [LINE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= '0;
        end else if (load_wr) begin
            wr_q <= wr_line_in;
        end
    end

    assign wr_word_out = wr_q[beat_idx*DATA_W +: DATA_W];

    for (genvar w = 0; w < BEATS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q[w*DATA_W +: DATA_W] <= '0;
            end else if (capture && (beat_idx == w[$clog2(BEATS)-1:0])) begin
                rd_q[w*DATA_W +: DATA_W] <= rd_word_in;
            end
        end
    end

    assign rd_line_out = rd_q;

endmodule

// File: rtl/wbl_burst_engine.sv
module wbl_burst_engine
    import wbl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINE_W = 128
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                evict_req,
    input  logic [ADDR_W-1:0]   evict_addr,
    input  logic [LINE_W-1:0]   evict_line,
    output logic                evict_done,
    input  logic                refill_req,
    input  logic [ADDR_W-1:0]   refill_addr,
    output logic [LINE_W-1:0]   refill_line,
    output logic                refill_done,
    output logic                wb_cyc_o,
    output logic                wb_stb_o,
    output logic                wb_we_o,
    output logic [ADDR_W-1:0]   wb_adr_o,
    output logic [DATA_W-1:0]   wb_dat_o,
    output logic [DATA_W/8-1:0] wb_sel_o,
    output logic [2:0]          wb_cti_o,
    output logic [1:0]          wb_bte_o,
    input  logic                wb_ack_i,
    input  logic [DATA_W-1:0]   wb_dat_i
);

    localparam int BEATS      = LINE_W / DATA_W;
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int IDX_W      = $clog2(BEATS);

    logic             start_push;
    logic             start_pull;
    logic             in_burst;
    logic             is_write;
    logic             last_beat;
    logic             step;
    logic [IDX_W-1:0] beat_idx;
    logic [DATA_W-1:0] wr_word;

    assign step = in_burst && wb_ack_i;

    wbl_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .evict_req   (evict_req),
        .refill_req  (refill_req),
        .ack         (step),
        .last_beat   (last_beat),
        .start_push  (start_push),
        .start_pull  (start_pull),
        .in_burst    (in_burst),
        .is_write    (is_write),
        .evict_done  (evict_done),
        .refill_done (refill_done)
    );

    wbl_beat_gen #(
        .ADDR_W     (ADDR_W),
        .BEATS      (BEATS),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_beat (
        .clk        (clk),
        .rst        (rst),
        .start      (start_push || start_pull),
        .start_addr (start_push ? evict_addr : refill_addr),
        .step       (step),
        .beat_idx   (beat_idx),
        .last_beat  (last_beat),
        .bus_addr   (wb_adr_o)
    );

    wbl_line_buf #(
        .DATA_W (DATA_W),
        .BEATS  (BEATS)
    ) u_buf (
        .clk         (clk),
        .rst         (rst),
        .load_wr     (start_push),
        .wr_line_in  (evict_line),
        .capture     (step && !is_write),
        .beat_idx    (beat_idx),
        .rd_word_in  (wb_dat_i),
        .wr_word_out (wr_word),
        .rd_line_out (refill_line)
    );

    assign wb_cyc_o = in_burst;
    assign wb_stb_o = in_burst;
    assign wb_we_o  = is_write;
    assign wb_dat_o = is_write ? wr_word : '0;
    assign wb_sel_o = '1;
    assign wb_cti_o = last_beat ? CTI_EOB : CTI_INCR;
    assign wb_bte_o = BTE_LINEAR;

endmodule

// File: rtl/wbl_burst_engine_chk.sv
module wbl_burst_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINE_W = 128
) (
    input logic                clk,
    input logic                rst,
    input logic                evict_req,
    input logic                evict_done,
    input logic                refill_done,
    input logic [LINE_W-1:0]   refill_line,
    input logic                wb_cyc_o,
    input logic                wb_stb_o,
    input logic                wb_we_o,
    input logic [ADDR_W-1:0]   wb_adr_o,
    input logic [DATA_W/8-1:0] wb_sel_o,
    input logic [2:0]          wb_cti_o,
    input logic [1:0]          wb_bte_o,
    input logic                wb_ack_i
);

    logic eob;
    assign eob = wb_cyc_o && wb_ack_i && (wb_cti_o == 3'b111);

    p_start_align_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_cyc_o) |-> (wb_adr_o[3:0] == 4'h0 && wb_stb_o));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && wb_ack_i && wb_cti_o != 3'b111) |=>
            (wb_cyc_o && wb_adr_o == $past(wb_adr_o) + 4));

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && $stable(wb_adr_o) && $stable(wb_cti_o)));

    p_fixed_fields_r4: assert property (@(posedge clk) disable iff (rst)
        wb_cyc_o |-> (wb_sel_o == '1 && wb_bte_o == 2'b00 &&
                      (wb_cti_o == 3'b010 || wb_cti_o == 3'b111)));

    p_end_drop_r7: assert property (@(posedge clk) disable iff (rst)
        eob |=> (!wb_cyc_o && !wb_stb_o && $onehot0({evict_done, refill_done})
                 && (evict_done || refill_done)));

    p_done_kind_r7: assert property (@(posedge clk) disable iff (rst)
        (eob && wb_we_o) |=> evict_done);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (evict_done || refill_done) |=> (!evict_done && !refill_done && !wb_cyc_o));

    p_evict_first_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(wb_cyc_o) && $past(evict_req)) |-> wb_we_o);

    p_line_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(wb_cyc_o && !wb_we_o && wb_ack_i) |=> $stable(refill_line));

endmodule

bind wbl_burst_engine wbl_burst_engine_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINE_W (LINE_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .evict_req   (evict_req),
    .evict_done  (evict_done),
    .refill_done (refill_done),
    .refill_line (refill_line),
    .wb_cyc_o    (wb_cyc_o),
    .wb_stb_o    (wb_stb_o),
    .wb_we_o     (wb_we_o),
    .wb_adr_o    (wb_adr_o),
    .wb_sel_o    (wb_sel_o),
    .wb_cti_o    (wb_cti_o),
    .wb_bte_o    (wb_bte_o),
    .wb_ack_i    (wb_ack_i)
);

// File: tb/tb_wbl_burst_engine.sv
`timescale 1ns/1ps
module tb_wbl_burst_engine;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         evict_req = 1'b0;
    logic [31:0]  evict_addr = '0;
    logic [127:0] evict_line = '0;
    logic         evict_done;
    logic         refill_req = 1'b0;
    logic [31:0]  refill_addr = '0;
    logic [127:0] refill_line;
    logic         refill_done;
    logic         wb_cyc_o, wb_stb_o, wb_we_o;
    logic [31:0]  wb_adr_o, wb_dat_o;
    logic [3:0]   wb_sel_o;
    logic [2:0]   wb_cti_o;
    logic [1:0]   wb_bte_o;
    logic         wb_ack_i;
    logic [31:0]  wb_dat_i;
    logic         ack_en = 1'b0;

    int checks = 0;
    int bad = 0;
    int ack_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit finished = 0;

    always #2 clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    assign wb_ack_i = wb_cyc_o && wb_stb_o && ack_en;
    assign wb_dat_i = wb_cyc_o ? mem_word(wb_adr_o) : 32'h0;

    wbl_burst_engine dut (
        .clk(clk), .rst(rst),
        .evict_req(evict_req), .evict_addr(evict_addr), .evict_line(evict_line),
        .evict_done(evict_done),
        .refill_req(refill_req), .refill_addr(refill_addr), .refill_line(refill_line),
        .refill_done(refill_done),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
        .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_sel_o(wb_sel_o),
        .wb_cti_o(wb_cti_o), .wb_bte_o(wb_bte_o),
        .wb_ack_i(wb_ack_i), .wb_dat_i(wb_dat_i)
    );

    task automatic chk(input bit ok, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // behavioural reference: 0 idle, 1 write burst, 2 read burst, 3 write end, 4 read end
    int           m_st = 0;
    int           m_beat = 0;
    logic [31:0]  m_base = '0;
    logic [127:0] m_wline = '0;
    logic [127:0] m_acc = '0;
    logic [127:0] m_fline = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_beat = 0; m_base = '0; m_wline = '0; m_acc = '0; m_fline = '0;
        end else begin
            case (m_st)
                0: begin
                    if (evict_req) begin
                        m_st = 1; m_beat = 0;
                        m_base = {evict_addr[31:4], 4'h0};
                        m_wline = evict_line;
                    end else if (refill_req) begin
                        m_st = 2; m_beat = 0;
                        m_base = {refill_addr[31:4], 4'h0};
                    end
                end
                1, 2: begin
                    if (ack_en) begin
                        if (m_st == 2) begin
                            m_acc[32*m_beat +: 32] = mem_word(m_base + 32'(4*m_beat));
                            m_fline = m_acc;
                        end
                        if (m_beat == 3) begin
                            m_st = (m_st == 1) ? 3 : 4;
                            m_beat = 0;
                        end else begin
                            m_beat = m_beat + 1;
                        end
                    end
                end
                default: m_st = 0;
            endcase
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit bus;
            bus = (m_st == 1 || m_st == 2);
            chk(wb_cyc_o == bus && wb_stb_o == bus, "R7 cyc/stb", {wb_cyc_o, wb_stb_o}, {bus, bus});
            if (bus) begin
                chk(wb_we_o == (m_st == 1), "R5 R6 we", wb_we_o, (m_st == 1));
                chk(wb_adr_o == m_base + 32'(4*m_beat), "R3 R10 adr", wb_adr_o, m_base + 32'(4*m_beat));
                if (m_beat == 0)
                    chk(wb_adr_o[3:0] == 4'h0, "R2 align", wb_adr_o, {wb_adr_o[31:4], 4'h0});
                chk(wb_cti_o == ((m_beat == 3) ? 3'b111 : 3'b010), "R4 cti",
                    wb_cti_o, (m_beat == 3) ? 3'b111 : 3'b010);
                chk(wb_sel_o == 4'hF && wb_bte_o == 2'b00, "R4 sel/bte",
                    {wb_sel_o, wb_bte_o}, {4'hF, 2'b00});
                if (m_st == 1)
                    chk(wb_dat_o == m_wline[32*m_beat +: 32], "R5 R10 dat",
                        wb_dat_o, m_wline[32*m_beat +: 32]);
            end
            chk(evict_done == (m_st == 3), "R7 evict_done", evict_done, (m_st == 3));
            chk(refill_done == (m_st == 4), "R7 refill_done", refill_done, (m_st == 4));
            if (m_st == 4)
                chk(refill_line == m_fline, "R6 line", refill_line, m_fline);
            else if (m_st != 2)
                chk(refill_line == m_fline, "R9 hold", refill_line, m_fline);
        end
    end

    // ack pattern
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ack_mode)
            0: ack_en <= 1'b1;
            1: ack_en <= ~ack_en;
            default: ack_en <= lfsr[0];
        endcase
    end

    task automatic run(input bit do_ev, input bit do_rf, input logic [31:0] ea,
                       input logic [127:0] el, input logic [31:0] ra,
                       input bit scramble, input bit check_order);
        bit ev_seen, rf_seen;
        int n;
        ev_seen = !do_ev; rf_seen = !do_rf; n = 0;
        @(negedge clk);
        evict_req = do_ev; evict_addr = ea; evict_line = el;
        refill_req = do_rf; refill_addr = ra;
        while (!(ev_seen && rf_seen) && n < 2000) begin
            @(negedge clk);
            n++;
            if (scramble && wb_cyc_o) begin
                evict_addr = ~evict_addr; evict_line = ~evict_line;
            end
            if (evict_done) begin
                ev_seen = 1; evict_req = 0;
            end
            if (refill_done) begin
                if (check_order)
                    chk(ev_seen, "R8 evict before refill", rf_seen, 1);
                rf_seen = 1; refill_req = 0;
            end
        end
        chk(n < 2000, "R7 completion", n, 2000);
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            $display("FAIL watchdog R7 act=timeout exp=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!wb_cyc_o && !wb_stb_o && !evict_done && !refill_done, "R1 reset outputs",
            {wb_cyc_o, wb_stb_o, evict_done, refill_done}, 0);
        chk(refill_line == '0, "R1 reset line", refill_line, 0);

        ack_mode = 0;
        run(1, 0, 32'h1000_0A37, 128'h4444_4444_3333_3333_2222_2222_1111_1111, 0, 0, 0);
        ack_mode = 1;
        run(0, 1, 0, 0, 32'h2000_1238, 0, 0);
        ack_mode = 2;
        run(1, 1, 32'h3000_004C, 128'hDEAD_BEEF_0BAD_F00D_CAFE_BABE_1234_5678,
            32'h4000_0050, 0, 1);
        ack_mode = 0;
        run(1, 1, 32'h5000_0000, 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0100,
            32'h6000_FFF0, 0, 1);
        // refill first, eviction arrives during it: no preemption
        ack_mode = 1;
        fork
            run(0, 1, 0, 0, 32'h7000_0110, 0, 0);
            begin
                repeat (4) @(negedge clk);
                evict_addr = 32'h7100_0200; evict_line = {4{32'hA5A5_5A5A}};
                evict_req = 1;
                while (!evict_done) @(negedge clk);
                evict_req = 0;
            end
        join
        repeat (3) @(negedge clk);
        // R10: inputs scrambled during the burst
        ack_mode = 2;
        run(1, 0, 32'h8000_0324, 128'h1111_2222_3333_4444_5555_6666_7777_8888, 0, 1, 0);
        ack_mode = 2;
        run(0, 1, 0, 0, 32'h9000_0AB0, 0, 0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule